// File: doc/BRIEF.md
# Column Scan Generator with Start-Line Offset

This block turns a dot-matrix display memory into per-column drive level codes, one scan line at a time. A frame marker pulse loads the programmed start line and clears the line count. Each rising edge of the shift clock moves one line down the screen. Between shift clock edges the block reads the next line as ten 8-bit pages through a synchronous RAM read port and holds them in a shadow buffer. On the next shift clock rise the shadow buffer moves into the 80 column latches.

Each latched bit is combined with the alternating polarity input to give one of four 2-bit level codes, and these codes drive analog switches outside the block. The RAM line read for screen row k is the start line plus k, wrapped within 64 lines. The row after the 64 display rows always reads the flag line, with no offset applied. Clearing the display-on input forces every column to the rail level code. The latches and the RAM are left as they are, so the image comes back as soon as the display is turned on again.

Top module: `col_scan_driver`

## Requirements
- R1: While and right after reset, every column code is 00 (the off code) and no RAM read is issued.
- R2: A rising edge on `frame_mark` loads `start_line` and clears the line count. The first shift clock rise after it latches RAM line `start_line`.
- R3: The n-th shift clock rise after a frame marker (n = 1..64) latches RAM line (`start_line` + n - 1) mod 64.
- R4: The 65th and every later shift clock rise in a frame latches the flag line. The flag line is read port line 64 (bit 6 set, low bits zero), whatever the start line.
- R5: Page p (0..9) of a line fills columns 8p to 8p+7, and bit b of the page byte goes to column 8p+b (column c occupies `col_level[2c+1:2c]`).
- R6: With the display on, a column's code is {polarity, NOT data}: 00 for polarity 0 and data 1, 01 for polarity 0 and data 0, 10 for polarity 1 and data 1, 11 for polarity 1 and data 0.
- R7: With `disp_on` low, every column code is 00 within two cycles. Raising it again brings back the latched image with no new shift clock edge.
- R8: A change of `start_line` takes effect only at the next frame marker. Lines already in the current frame keep the old offset.
- R9: Each line fetch issues exactly ten consecutive read cycles with pages 0,1,...,9 in order. Read data is taken one cycle after the read.
- R10: Column data changes only at a shift clock rise. RAM contents that change between rises do not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Line shift clock, synchronous to clk; rising edge latches a line |
| frame_mark | input | 1 | Frame start marker, synchronous to clk; rising edge restarts the scan |
| polarity | input | 1 | Alternating drive polarity |
| disp_on | input | 1 | Display enable; low forces the off code |
| start_line | input | 6 | Programmed top-of-screen RAM line |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_line | output | 7 | RAM line to read; 64 selects the flag line |
| ram_rd_page | output | 4 | RAM page (byte column group) to read |
| ram_rd_data | input | 8 | RAM read data, valid one cycle after the strobe |
| col_level | output | 160 | Two-bit drive level code per column |

## Verification
The assertions assume that `shift_clk` and `frame_mark` are already synchronous to `clk`. They also assume that a shift clock rise never lands while a line fetch is pending or running, which needs at least 13 clock cycles between an edge and the next one, and that the RAM answers one cycle after each read. The stimulus spaces every shift clock and frame marker edge 20 cycles apart and never fires the two together. A behavioural RAM with fixed latency answers the reads. Random RAM contents, start lines, polarity and line counts are mixed with directed runs through the 64-line wrap, the flag line, display off and on, a start-line change in mid-frame, and RAM edits between edges.

// File: rtl/colscan_pkg.sv
package colscan_pkg;
  typedef logic [1:0] lvl_t;

  // Level code for a lit/unlit pixel under the current polarity phase.
  function automatic lvl_t drive_code(input logic pol, input logic pix);
    return {pol, ~pix};
  endfunction
endpackage

// File: rtl/colscan_linectl.sv
module colscan_linectl #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl,
  input  logic              frm,
  input  logic [LINE_W-1:0] start_cfg,
  output logic              cl_rise,
  output logic              frm_rise,
  output logic              fetch_go,
  output logic [LINE_W:0]   rd_line
);
  logic              cl_q, frm_q, go_q;
  logic [LINE_W-1:0] start_q;
  logic [LINE_W:0]   lcnt;      // top bit set = flag line reached
  logic [LINE_W-1:0] disp_line;

  assign cl_rise  = cl & ~cl_q;
  assign frm_rise = frm & ~frm_q;
  assign fetch_go = go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q    <= 1'b0;
      frm_q   <= 1'b0;
      go_q    <= 1'b0;
      start_q <= '0;
      lcnt    <= '0;
    end else begin
      cl_q  <= cl;
      frm_q <= frm;
      go_q  <= 1'b0;
      if (frm_rise) begin
        start_q <= start_cfg;
        lcnt    <= '0;
        go_q    <= 1'b1;
      end else if (cl_rise) begin
        if (!lcnt[LINE_W]) lcnt <= lcnt + 1'b1;
        go_q <= 1'b1;
      end
    end
  end

  assign disp_line = start_q + lcnt[LINE_W-1:0];
  assign rd_line   = lcnt[LINE_W] ? {1'b1, {LINE_W{1'b0}}} : {1'b0, disp_line};

  assert_frame_load_R2: assert property (@(posedge clk) disable iff (rst)
    frm_rise |=> (lcnt == '0) && (start_q == $past(start_cfg)));
  assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
    cl_rise && !frm_rise && !lcnt[LINE_W] |=> lcnt == $past(lcnt) + 1'b1);
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (rst)
    cl_rise && !frm_rise && lcnt[LINE_W] |=> lcnt == $past(lcnt));
  assert_start_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frm_rise |=> $stable(start_q));
endmodule

// File: rtl/colscan_fetch.sv
module colscan_fetch #(
  parameter int PAGES  = 10,
  parameter int PAGE_W = 8,
  localparam int PG_W  = $clog2(PAGES),
  localparam int COLS  = PAGES * PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              cl_rise,
  input  logic [PAGE_W-1:0] rd_data,
  output logic              rd_en,
  output logic [PG_W-1:0]   rd_page,
  output logic [COLS-1:0]   shadow
);
  logic            busy, vld_q;
  logic [PG_W-1:0] pg, pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      pg     <= '0;
      vld_q  <= 1'b0;
      pg_q   <= '0;
      shadow <= '0;
    end else begin
      vld_q <= busy;
      pg_q  <= pg;
      if (go) begin
        busy <= 1'b1;
        pg   <= '0;
      end else if (busy) begin
        if (pg == PG_W'(PAGES-1)) busy <= 1'b0;
        else                      pg   <= pg + 1'b1;
      end
      for (int p = 0; p < PAGES; p++)
        if (vld_q && pg_q == PG_W'(p))
          shadow[p*PAGE_W +: PAGE_W] <= rd_data;
    end
  end

  assign rd_en   = busy;
  assign rd_page = pg;

  assert_burst_start_R9: assert property (@(posedge clk) disable iff (rst)
    go |=> rd_en && (rd_page == '0));
  assert_page_step_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en && $past(rd_en) |-> rd_page == $past(rd_page) + 1'b1);
  assert_burst_end_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en && (rd_page == PG_W'(PAGES-1)) |=> !rd_en || (rd_page == '0));
  // Input assumption: shift edges stay clear of a running fetch.
  assert_edge_gap_R10: assert property (@(posedge clk) disable iff (rst)
    cl_rise |-> !busy && !go && !vld_q);
endmodule

// File: rtl/colscan_drive.sv
module colscan_drive
  import colscan_pkg::*;
#(
  parameter int   COLS     = 80,
  parameter lvl_t OFF_CODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_rise,
  input  logic [COLS-1:0]   shadow,
  input  logic              pol,
  input  logic              disp_on,
  output logic [2*COLS-1:0] lvl
);
  logic [COLS-1:0]   latch_q;
  logic [2*COLS-1:0] lvl_d;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign lvl_d[2*c +: 2] = disp_on ? drive_code(pol, latch_q[c]) : OFF_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      lvl     <= {COLS{OFF_CODE}};
    end else begin
      if (cl_rise) latch_q <= shadow;
      lvl <= lvl_d;
    end
  end

  assert_off_level_R7: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> lvl == {COLS{OFF_CODE}});
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cl_rise |=> $stable(latch_q));
  assert_col0_code_R6: assert property (@(posedge clk) disable iff (rst)
    disp_on |=> lvl[1:0] == {$past(pol), ~$past(latch_q[0])});
endmodule

// File: rtl/col_scan_driver.sv
module col_scan_driver
  import colscan_pkg::*;
#(
  parameter int   LINE_W   = 6,
  parameter int   PAGES    = 10,
  parameter int   PAGE_W   = 8,
  parameter lvl_t OFF_CODE = 2'b00,
  localparam int  PG_W     = $clog2(PAGES),
  localparam int  COLS     = PAGES * PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_clk,
  input  logic              frame_mark,
  input  logic              polarity,
  input  logic              disp_on,
  input  logic [LINE_W-1:0] start_line,
  output logic              ram_rd_en,
  output logic [LINE_W:0]   ram_rd_line,
  output logic [PG_W-1:0]   ram_rd_page,
  input  logic [PAGE_W-1:0] ram_rd_data,
  output logic [2*COLS-1:0] col_level
);
  logic            cl_rise, frm_rise, fetch_go;
  logic [COLS-1:0] shadow;

  colscan_linectl #(.LINE_W(LINE_W)) u_linectl (
    .clk(clk), .rst(rst), .cl(shift_clk), .frm(frame_mark),
    .start_cfg(start_line), .cl_rise(cl_rise), .frm_rise(frm_rise),
    .fetch_go(fetch_go), .rd_line(ram_rd_line)
  );

  colscan_fetch #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .cl_rise(cl_rise),
    .rd_data(ram_rd_data), .rd_en(ram_rd_en), .rd_page(ram_rd_page),
    .shadow(shadow)
  );

  colscan_drive #(.COLS(COLS), .OFF_CODE(OFF_CODE)) u_drive (
    .clk(clk), .rst(rst), .cl_rise(cl_rise), .shadow(shadow),
    .pol(polarity), .disp_on(disp_on), .lvl(col_level)
  );

  assert_no_edge_clash_R2: assert property (@(posedge clk) disable iff (rst)
    !(cl_rise && frm_rise));
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !ram_rd_en && (col_level == {COLS{OFF_CODE}}));
endmodule

// File: tb/col_scan_driver_tb.sv
`timescale 1ns/1ps
module col_scan_driver_tb;
  localparam int PAGES = 10;
  localparam int COLS  = 80;
  localparam int NLINE = 65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk = 1'b0, frame_mark = 1'b0, polarity = 1'b0, disp_on = 1'b0;
  logic [5:0] start_line = '0;
  logic ram_rd_en;
  logic [6:0] ram_rd_line;
  logic [3:0] ram_rd_page;
  logic [7:0] ram_rd_data = '0;
  logic [2*COLS-1:0] col_level;

  logic [7:0] ram [0:NLINE*PAGES-1];
  int checks = 0, failures = 0;
  int cur_start = 0, n_cl = 0;
  int rd_cnt = 0;
  bit order_bad = 0, done = 0;

  always #2.5 clk = ~clk;

  col_scan_driver u_dut (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .frame_mark(frame_mark),
    .polarity(polarity), .disp_on(disp_on), .start_line(start_line),
    .ram_rd_en(ram_rd_en), .ram_rd_line(ram_rd_line), .ram_rd_page(ram_rd_page),
    .ram_rd_data(ram_rd_data), .col_level(col_level)
  );

  // Behavioural RAM, one-cycle read latency
  always @(posedge clk)
    ram_rd_data <= ram_rd_en ? ram[int'(ram_rd_line)*PAGES + int'(ram_rd_page)] : 8'h00;

  // Read-burst monitor
  always @(negedge clk)
    if (ram_rd_en) begin
      if (int'(ram_rd_page) != rd_cnt) order_bad = 1;
      rd_cnt++;
    end

  function automatic int line_of(int s, int k);
    return (k < 64) ? ((s + k) % 64) : 64;
  endfunction

  function automatic logic [2*COLS-1:0] exp_lvl(int line, logic p, logic on);
    logic [2*COLS-1:0] v;
    for (int c = 0; c < COLS; c++) begin
      logic d;
      d = ram[line*PAGES + c/8][c%8];
      v[2*c +: 2] = on ? {p, ~d} : 2'b00;
    end
    return v;
  endfunction

  task automatic chk(string req, logic [2*COLS-1:0] act, logic [2*COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(int s);
    @(negedge clk);
    start_line = 6'(s);
    frame_mark = 1'b1;
    rd_cnt = 0; order_bad = 0;
    @(negedge clk);
    frame_mark = 1'b0;
    repeat (18) @(negedge clk);
    cur_start = s;
    n_cl = 0;
  endtask

  task automatic line_step();
    @(negedge clk);
    shift_clk = 1'b1;
    rd_cnt = 0; order_bad = 0;
    repeat (2) @(negedge clk);
    shift_clk = 1'b0;
    repeat (18) @(negedge clk);
    n_cl++;
  endtask

  task automatic check_line(string req);
    chk(req, col_level, exp_lvl(line_of(cur_start, n_cl-1), polarity, disp_on));
  endtask

  initial begin
    logic [2*COLS-1:0] saved;
    void'($urandom(32'd4177));
    for (int i = 0; i < NLINE*PAGES; i++) ram[i] = 8'($urandom);

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 reset level", col_level, '0);
    chk_int("R1 no read in reset", int'(ram_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", col_level, '0);
    disp_on = 1'b1;

    // R2/R5/R9: first line after frame marker
    frame(0);
    line_step();
    check_line("R2 R5 first line start=0");
    chk_int("R9 reads per line", rd_cnt, 10);
    chk_int("R9 page order", int'(order_bad), 0);

    // R6: both polarities on the same latched line
    @(negedge clk) polarity = 1'b1;
    repeat (3) @(negedge clk);
    check_line("R6 polarity 1");
    @(negedge clk) polarity = 1'b0;
    repeat (3) @(negedge clk);
    check_line("R6 polarity 0");

    // R3/R4/R8: full frame with wrap and flag line
    frame(50);
    for (int k = 0; k < 70; k++) begin
      polarity = 1'($urandom);
      if (k == 30) start_line = 6'd5;
      line_step();
      if (k >= 64)      check_line("R4 flag line");
      else if (k > 30)  check_line("R8 R3 old offset kept");
      else              check_line("R3 offset line");
    end
    chk_int("R9 reads on flag line", rd_cnt, 10);

    // R7: display off and back on
    @(negedge clk) disp_on = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 display off", col_level, '0);
    @(negedge clk) disp_on = 1'b1;
    repeat (3) @(negedge clk);
    check_line("R7 image restored");

    // R10: RAM change between shift edges has no effect
    frame(12);
    line_step();
    saved = exp_lvl(line_of(12, 0), polarity, 1'b1);
    ram[12*PAGES + 3] = ~ram[12*PAGES + 3];
    ram[13*PAGES + 0] = ~ram[13*PAGES + 0];
    repeat (10) @(negedge clk);
    chk("R10 latched held", col_level, saved);

    // Random frames
    for (int f = 0; f < 6; f++) begin
      int nl;
      frame(int'($urandom_range(0, 63)));
      nl = int'($urandom_range(3, 12));
      for (int k = 0; k < nl; k++) begin
        polarity = 1'($urandom);
        line_step();
        check_line("R3 R6 random frame");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule